// File: doc/BRIEF.md
# Row/Column Display Register Writer over I2C

This block is a write-only I2C target that fills a memory of 16-bit display registers, each selected by a row and a column. SCL and SDA are sampled with the system clock through synchronisers. Bus START and STOP are found from edges of the sampled lines. When the first byte after a START carries the block's own device address with the write bit, the block acknowledges that byte and every byte that follows it.

The two bytes after the device address form the register address. The first of them gives the row and the second gives the starting column. Later bytes are paired into 16-bit words, and each word becomes one write strobe on the memory-side outputs. The column then steps to the next register, so a host can fill a run of a row in one transaction. An unfinished word is discarded when the transaction ends or restarts.

Top module: `dispreg_i2c_writer`

## Requirements
- R1: After reset, wr_en and sda_pull_low are 0 and wr_row, wr_col and wr_data are all zero.
- R2: A first byte of 0xBA after a START (7-bit address 0x5D, write bit 0) is acknowledged. sda_pull_low is 1 while SCL is high in the ninth clock of that byte, and it changes only while SCL is low.
- R3: A first byte other than 0xBA is not acknowledged, and this includes 0xBB, the read form. Until the next START, no later byte is acknowledged and no write is issued.
- R4: The byte after an accepted device address sets the row from its bits 3:0, and bits 7:4 have no effect.
- R5: The next byte sets the starting column from its bits 4:0, and bits 7:5 have no effect.
- R6: Both address bytes and every data byte of an accepted transaction are acknowledged.
- R7: Data bytes pair into one word with the first byte as bits 15:8. A completed word gives a one-cycle wr_en pulse, with wr_row, wr_col and wr_data holding the row, the current column and the word.
- R8: After each written word the column increments by one, modulo 32, and the row stays the same.
- R9: A STOP that arrives with an odd number of data bytes discards the unpaired byte, and no write results from it.
- R10: A repeated START discards any unpaired data byte and restarts the transaction with the device address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | I2C clock line level |
| sda_in | input | 1 | I2C data line level as seen on the bus |
| sda_pull_low | output | 1 | When 1, the open-drain pad pulls SDA low (acknowledge) |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_row | output | 4 | Row of the register being written |
| wr_col | output | 5 | Column of the register being written |
| wr_data | output | 16 | Word to be written |

## Verification
The hardest case to reach is a transaction that ends or restarts while a word is half assembled. Nothing at the ports shows the held byte, so the only evidence that it was dropped is that no write comes from it, both at the boundary and in later traffic. The bench sends an odd number of data bytes and then closes the transaction with a STOP in one test and with a repeated START in another. After each, it counts and checks every write strobe, including the first word of the following transaction. The bench models the bus as a wired-AND of the host and the block's pull-down, so each acknowledge is read from the line itself.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DEV,
    PH_ROW,
    PH_COL,
    PH_DATA
  } phase_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_prev;
  logic              sda_prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_chain[0] <= 1'b1;
            sda_chain[0] <= 1'b1;
          end else begin
            scl_chain[0] <= scl_in;
            sda_chain[0] <= sda_in;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) begin
            scl_chain[g] <= 1'b1;
            sda_chain[g] <= 1'b1;
          end else begin
            scl_chain[g] <= scl_chain[g-1];
            sda_chain[g] <= sda_chain[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_chain[STAGES-1];
      sda_prev <= sda_chain[STAGES-1];
    end
  end

  assign scl_lvl   = scl_chain[STAGES-1];
  assign sda_lvl   = sda_chain[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cw_shifter.sv
module i2cw_shifter
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              ack_take,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              sda_pull
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic              in_ack;
  logic              busy;
  logic [BYTE_W-1:0] shreg;

  always_ff @(posedge clk) begin
    byte_done <= 1'b0;
    if (rst) begin
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      busy     <= 1'b0;
      sda_pull <= 1'b0;
      shreg    <= '0;
    end else if (start_det) begin
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      busy     <= 1'b1;
      sda_pull <= 1'b0;
    end else if (stop_det) begin
      bit_cnt  <= '0;
      in_ack   <= 1'b0;
      busy     <= 1'b0;
      sda_pull <= 1'b0;
    end else if (busy) begin
      if (scl_rise && !in_ack && bit_cnt < FULL) begin
        shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) byte_done <= 1'b1;
      end else if (scl_fall && in_ack) begin
        in_ack   <= 1'b0;
        sda_pull <= 1'b0;
        bit_cnt  <= '0;
      end else if (scl_fall && bit_cnt == FULL) begin
        in_ack   <= 1'b1;
        sda_pull <= ack_take;
      end
    end
  end

  assign byte_val = shreg;
endmodule

// File: rtl/i2cw_ctrl.sv
module i2cw_ctrl
  import i2cw_pkg::*;
#(
  parameter int         ROW_W     = 4,
  parameter int         COL_W     = 5,
  parameter logic [6:0] DEV_ADDR7 = 7'h5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output logic              ack_take,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [WORD_W-1:0] wr_data,
  output logic              half_valid,
  output logic              in_data
);
  localparam logic [BYTE_W-1:0] WR_ADDR = {DEV_ADDR7, 1'b0};

  phase_t            phase;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [BYTE_W-1:0] hi_byte;

  always_ff @(posedge clk) begin
    wr_en <= 1'b0;
    if (rst) begin
      phase      <= PH_IDLE;
      row_q      <= '0;
      col_q      <= '0;
      hi_byte    <= '0;
      half_valid <= 1'b0;
      ack_take   <= 1'b0;
      wr_row     <= '0;
      wr_col     <= '0;
      wr_data    <= '0;
    end else if (start_det) begin
      phase      <= PH_DEV;
      half_valid <= 1'b0;
      ack_take   <= 1'b0;
    end else if (stop_det) begin
      phase      <= PH_IDLE;
      half_valid <= 1'b0;
      ack_take   <= 1'b0;
    end else if (byte_done) begin
      unique case (phase)
        PH_DEV: begin
          if (byte_val == WR_ADDR) begin
            ack_take <= 1'b1;
            phase    <= PH_ROW;
          end else begin
            ack_take <= 1'b0;
            phase    <= PH_IDLE;
          end
        end
        PH_ROW: begin
          row_q    <= byte_val[ROW_W-1:0];
          ack_take <= 1'b1;
          phase    <= PH_COL;
        end
        PH_COL: begin
          col_q    <= byte_val[COL_W-1:0];
          ack_take <= 1'b1;
          phase    <= PH_DATA;
        end
        PH_DATA: begin
          ack_take <= 1'b1;
          if (!half_valid) begin
            hi_byte    <= byte_val;
            half_valid <= 1'b1;
          end else begin
            half_valid <= 1'b0;
            wr_en      <= 1'b1;
            wr_row     <= row_q;
            wr_col     <= col_q;
            wr_data    <= {hi_byte, byte_val};
            col_q      <= col_q + 1'b1;
          end
        end
        default: ack_take <= 1'b0;
      endcase
    end
  end

  assign in_data = (phase == PH_DATA);
endmodule

// File: rtl/dispreg_i2c_writer.sv
module dispreg_i2c_writer
  import i2cw_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ROW_W       = 4,
  parameter int         COL_W       = 5,
  parameter logic [6:0] DEV_ADDR7   = 7'h5D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_pull_low,
  output logic              wr_en,
  output logic [ROW_W-1:0]  wr_row,
  output logic [COL_W-1:0]  wr_col,
  output logic [WORD_W-1:0] wr_data
);
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall;
  logic              start_det, stop_det;
  logic              byte_done, ack_take;
  logic [BYTE_W-1:0] byte_val;
  logic              half_valid, in_data;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_shifter u_shift (
    .clk(clk), .rst(rst), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .ack_take(ack_take), .byte_done(byte_done), .byte_val(byte_val),
    .sda_pull(sda_pull_low)
  );

  i2cw_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DEV_ADDR7(DEV_ADDR7)) u_ctrl (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .byte_done(byte_done), .byte_val(byte_val), .ack_take(ack_take),
    .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col), .wr_data(wr_data),
    .half_valid(half_valid), .in_data(in_data)
  );
endmodule

// File: rtl/dispreg_i2c_writer_chk.sv
module dispreg_i2c_writer_chk #(
  parameter int COL_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [COL_W-1:0] wr_col,
  input logic             sda_pull_low,
  input logic             scl_lvl,
  input logic             start_det,
  input logic             stop_det,
  input logic             half_valid,
  input logic             in_data
);
  logic             seen_wr;
  logic [COL_W-1:0] last_col;

  always_ff @(posedge clk) begin
    if (rst || start_det || stop_det) begin
      seen_wr  <= 1'b0;
      last_col <= '0;
    end else if (wr_en) begin
      seen_wr  <= 1'b1;
      last_col <= wr_col;
    end
  end

  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en); // R7
  AST_WR_ONLY_IN_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> in_data); // R3
  AST_COL_STEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seen_wr) |-> (wr_col == last_col + 1'b1)); // R8
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull_low) |-> !scl_lvl); // R2
  AST_STOP_DROPS_HALF: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !half_valid); // R9
  AST_START_DROPS_HALF: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !half_valid); // R10
endmodule

bind dispreg_i2c_writer dispreg_i2c_writer_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_col(wr_col),
  .sda_pull_low(sda_pull_low), .scl_lvl(scl_lvl), .start_det(start_det),
  .stop_det(stop_det), .half_valid(half_valid), .in_data(in_data)
);

// File: tb/dispreg_i2c_writer_test.sv
`timescale 1ns/1ps
module dispreg_i2c_writer_test;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic sda_pull_low, wr_en;
  logic [3:0]  wr_row;
  logic [4:0]  wr_col;
  logic [15:0] wr_data;
  wire  sda_bus = host_sda & ~sda_pull_low;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;
  int wr_count = 0;
  logic [24:0] wlog [0:63];

  always #10 clk = ~clk;

  dispreg_i2c_writer uut (
    .clk(clk), .rst(rst), .scl_in(host_scl), .sda_in(sda_bus),
    .sda_pull_low(sda_pull_low), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (wr_count < 64) wlog[wr_count] = {wr_row, wr_col, wr_data};
      wr_count = wr_count + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq(1);
    host_scl = 1'b1; wq(1);
    host_sda = 1'b0; wq(1);
    host_scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq(1);
    host_scl = 1'b1; wq(1);
    host_sda = 1'b1; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      host_sda = b[i]; wq(1);
      host_scl = 1'b1; wq(2);
      host_scl = 1'b0; wq(1);
    end
    host_sda = 1'b1; wq(1);
    host_scl = 1'b1; wq(1);
    acked = ~sda_bus;
    wq(1);
    host_scl = 1'b0; wq(1);
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send_byte(b, a);
    chk(req, {31'd0, a}, {31'd0, exp_ack});
  endtask

  task automatic chk_wr(input int idx, input logic [3:0] r, input logic [4:0] c,
                        input logic [15:0] d, input string req);
    chk(req, {7'd0, wlog[idx]}, {7'd0, r, c, d});
  endtask

  task automatic t_reset();
    chk("R1 wr_en", {31'd0, wr_en}, 32'd0);
    chk("R1 pull", {31'd0, sda_pull_low}, 32'd0);
    chk("R1 outs", {7'd0, wr_row, wr_col, wr_data}, 32'd0);
  endtask

  task automatic t_basic();
    int base = wr_count;
    bus_start();
    send_chk(8'hBA, 1'b1, "R2 dev ack");
    send_chk(8'hF3, 1'b1, "R6 row ack");
    send_chk(8'hE5, 1'b1, "R6 col ack");
    send_chk(8'h12, 1'b1, "R6 data ack");
    send_chk(8'h34, 1'b1, "R6 data ack");
    send_chk(8'h56, 1'b1, "R6 data ack");
    send_chk(8'h78, 1'b1, "R6 data ack");
    bus_stop();
    chk("R7 count", wr_count - base, 2);
    chk_wr(base, 4'd3, 5'd5, 16'h1234, "R4 R5 R7 first word");
    chk_wr(base + 1, 4'd3, 5'd6, 16'h5678, "R8 next column");
  endtask

  task automatic t_wrong_addr();
    int base = wr_count;
    bus_start();
    send_chk(8'hB8, 1'b0, "R3 other addr nack");
    send_chk(8'h01, 1'b0, "R3 ignored byte");
    send_chk(8'h02, 1'b0, "R3 ignored byte");
    send_chk(8'h11, 1'b0, "R3 ignored byte");
    send_chk(8'h22, 1'b0, "R3 ignored byte");
    bus_stop();
    bus_start();
    send_chk(8'hBB, 1'b0, "R3 read addr nack");
    send_chk(8'h00, 1'b0, "R3 ignored byte");
    bus_stop();
    chk("R3 no writes", wr_count - base, 0);
  endtask

  task automatic t_stop_drop();
    int base = wr_count;
    bus_start();
    send_chk(8'hBA, 1'b1, "R2 dev ack");
    send_chk(8'h00, 1'b1, "R6 row ack");
    send_chk(8'h00, 1'b1, "R6 col ack");
    send_chk(8'hAA, 1'b1, "R6 data ack");
    send_chk(8'hBB, 1'b1, "R6 data ack");
    send_chk(8'hCC, 1'b1, "R6 data ack");
    bus_stop();
    chk("R9 count", wr_count - base, 1);
    chk_wr(base, 4'd0, 5'd0, 16'hAABB, "R9 kept word");
    bus_start();
    send_chk(8'hBA, 1'b1, "R2 dev ack");
    send_chk(8'h07, 1'b1, "R6 row ack");
    send_chk(8'h09, 1'b1, "R6 col ack");
    send_chk(8'h44, 1'b1, "R6 data ack");
    send_chk(8'h55, 1'b1, "R6 data ack");
    bus_stop();
    chk("R9 next count", wr_count - base, 2);
    chk_wr(base + 1, 4'd7, 5'd9, 16'h4455, "R9 no stale high byte");
  endtask

  task automatic t_restart_wrap();
    int base = wr_count;
    bus_start();
    send_chk(8'hBA, 1'b1, "R2 dev ack");
    send_chk(8'h02, 1'b1, "R6 row ack");
    send_chk(8'h1F, 1'b1, "R6 col ack");
    send_chk(8'hDE, 1'b1, "R6 data ack");
    send_chk(8'hAD, 1'b1, "R6 data ack");
    send_chk(8'h01, 1'b1, "R6 data ack");
    bus_start();
    send_chk(8'hBA, 1'b1, "R10 dev ack after restart");
    send_chk(8'h14, 1'b1, "R4 row ack");
    send_chk(8'hFF, 1'b1, "R5 col ack");
    send_chk(8'hBE, 1'b1, "R6 data ack");
    send_chk(8'hEF, 1'b1, "R6 data ack");
    send_chk(8'hC0, 1'b1, "R6 data ack");
    send_chk(8'hDE, 1'b1, "R6 data ack");
    bus_stop();
    chk("R10 count", wr_count - base, 3);
    chk_wr(base, 4'd2, 5'd31, 16'hDEAD, "R10 word before restart");
    chk_wr(base + 1, 4'd4, 5'd31, 16'hBEEF, "R10 R4 R5 masked fields");
    chk_wr(base + 2, 4'd4, 5'd0, 16'hC0DE, "R8 column wrap");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_wrong_addr();
    t_stop_drop();
    t_restart_wrap();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule